// File: doc/BRIEF.md
# I2C Bus Fault Monitor

This monitor sits inside an I2C controller, next to the transfer state machines. Its inputs are single-cycle START and STOP indications from the condition detector, the frame phase the transfer logic is in, and the role the controller plays on the bus. A START or STOP inside an address byte, a data byte or an acknowledge bit is a misplaced condition. It only counts when the controller is a master or an addressed slave. The monitor then raises a one-cycle fault pulse, sets the interrupt flag, loads status code 00H and holds a line-release command. The pulse tells the transfer logic to drop back to not-addressed slave mode.

The monitor also holds the four software control bits: start request, stop request, interrupt flag and acknowledge enable. Software leaves the fault state by setting the stop bit and clearing the interrupt flag in one write. The monitor then clears the stop bit and leaves the other bits as written. It drops the line-release command and never asks for a STOP to be driven during this recovery. While the interrupt flag is low, the status reads F8H.

Top module: `i2c_bus_fault_mon`

## Requirements
- R1: After reset the interrupt flag, stop bit, start bit, acknowledge bit, line release and fault pulse are all 0, and the status reads F8H.
- R2: A START or STOP pulse while `frame_phase` is 1 (address), 2 (data) or 3 (acknowledge) and `ctl_role` is 1 (master) or 2 (addressed slave) gives `bus_err_pulse` high in the next cycle, for that one cycle only.
- R3: While `ctl_role` is 0 (not-addressed slave) or 3 (reserved), START and STOP pulses change no output.
- R4: A START or STOP while `frame_phase` is 0 (between bytes) changes no output.
- R5: In the cycle the fault pulse is high, the interrupt flag is 1, the status reads 00H and `line_release` is 1. Release stays high until recovery.
- R6: A START or STOP input held high for several cycles gives exactly one fault pulse.
- R7: `ctl_wdata` bits are [3] start, [2] stop, [1] interrupt flag, [0] acknowledge. A write with stop=1 and flag=0 during a fault stores the written bits. One cycle later the stop bit reads 0, `line_release` reads 0 and the status reads F8H, while start and acknowledge keep their written values.
- R8: `stop_req` is high only when the stop bit is set, the role is master and no fault is pending. It is never high during fault recovery.
- R9: A software write can clear the interrupt flag but cannot set it. Outside a fault, `stop_done` clears the stop bit.
- R10: While a fault is pending, further misplaced conditions give no new pulse, and the status stays 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_det | input | 1 | START condition seen |
| stop_det | input | 1 | STOP condition seen |
| frame_phase | input | 2 | 0 between bytes, 1 address, 2 data, 3 acknowledge |
| ctl_role | input | 2 | 0 not-addressed slave, 1 master, 2 addressed slave, 3 reserved |
| ctl_we | input | 1 | software control write strobe |
| ctl_wdata | input | 4 | written control bits {start, stop, flag, ack} |
| stop_done | input | 1 | transfer logic finished a normal STOP |
| bus_err_pulse | output | 1 | one-cycle fault indication |
| line_release | output | 1 | release SDA and SCL |
| si_flag | output | 1 | interrupt flag |
| sta_flag | output | 1 | start request bit |
| sto_flag | output | 1 | stop request bit |
| aa_flag | output | 1 | acknowledge enable bit |
| stop_req | output | 1 | ask the transfer logic to send a STOP |
| status_code | output | 8 | status view |

## Verification
Every result of a condition pulse is due one clock after the cycle that presents it: the fault pulse, the flag, the status and the release. The bench drives on the falling edge and reads at the following falling edge. A recovery write shows its stored bits one edge after the write. The cleared stop bit and the dropped release show one edge later, so the bench checks both of these cycles. The sweep covers every phase, role and condition kind, with the expected fault worked out from the phase and role codes.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  typedef enum logic [1:0] {PH_GAP = 2'd0, PH_ADDR = 2'd1, PH_DATA = 2'd2, PH_ACK = 2'd3} phase_e;
  typedef enum logic [1:0] {RL_IDLE = 2'd0, RL_MASTER = 2'd1, RL_SLAVE = 2'd2, RL_RSVD = 2'd3} role_e;

  typedef struct packed {
    logic sta;
    logic sto;
    logic si;
    logic aa;
  } ctl_t;

  function automatic logic inside_frame(input logic [1:0] ph);
    return ph != PH_GAP;
  endfunction

  function automatic logic engaged(input logic [1:0] rl);
    return (rl == RL_MASTER) || (rl == RL_SLAVE);
  endfunction

  function automatic logic [7:0] status_view(input logic si, input logic [7:0] code,
                                             input logic [7:0] idle_code);
    return si ? code : idle_code;
  endfunction
endpackage

// File: rtl/bfm_detect.sv
module bfm_detect
  import bfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] frame_phase,
  input  logic [1:0] ctl_role,
  input  logic       fault_pending,
  output logic       err_evt,
  output logic       err_pulse
);
  logic raw_hit, raw_q;

  assign raw_hit = (start_det | stop_det) & inside_frame(frame_phase) & engaged(ctl_role);
  assign err_evt = raw_hit & ~raw_q & ~fault_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q     <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      raw_q     <= raw_hit;
      err_pulse <= err_evt;
    end
  end
endmodule

// File: rtl/bfm_ctl.sv
module bfm_ctl
  import bfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_evt,
  input  logic       ctl_we,
  input  logic [3:0] ctl_wdata,
  input  logic       stop_done,
  output ctl_t       ctl_q,
  output logic       fault_pending,
  output logic       recover
);
  ctl_t wr;
  assign wr      = ctl_t'(ctl_wdata);
  assign recover = fault_pending & ctl_q.sto & ~ctl_q.si;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q         <= '0;
      fault_pending <= 1'b0;
    end else begin
      if (ctl_we) begin
        ctl_q.sta <= wr.sta;
        ctl_q.sto <= wr.sto;
        ctl_q.aa  <= wr.aa;
        if (!wr.si) ctl_q.si <= 1'b0;
      end
      if (stop_done && !fault_pending) ctl_q.sto <= 1'b0;
      if (recover) begin
        ctl_q.sto     <= 1'b0;
        fault_pending <= 1'b0;
      end
      if (err_evt) begin
        ctl_q.si      <= 1'b1;
        fault_pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bfm_status.sv
module bfm_status
  import bfm_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter logic [STAT_W-1:0] ERR_CODE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_evt,
  output logic [STAT_W-1:0] code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= ERR_CODE;
    else if (err_evt) code_q <= ERR_CODE;
  end
endmodule

// File: rtl/i2c_bus_fault_mon.sv
module i2c_bus_fault_mon
  import bfm_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter logic [STAT_W-1:0] ERR_CODE  = 8'h00,
  parameter logic [STAT_W-1:0] IDLE_CODE = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        frame_phase,
  input  logic [1:0]        ctl_role,
  input  logic              ctl_we,
  input  logic [3:0]        ctl_wdata,
  input  logic              stop_done,
  output logic              bus_err_pulse,
  output logic              line_release,
  output logic              si_flag,
  output logic              sta_flag,
  output logic              sto_flag,
  output logic              aa_flag,
  output logic              stop_req,
  output logic [STAT_W-1:0] status_code
);
  logic              err_evt;
  logic              fault_pending;
  logic              recover;
  ctl_t              ctl_q;
  logic [STAT_W-1:0] code_q;

  bfm_detect u_detect (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .frame_phase(frame_phase), .ctl_role(ctl_role), .fault_pending(fault_pending),
    .err_evt(err_evt), .err_pulse(bus_err_pulse)
  );

  bfm_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .stop_done(stop_done), .ctl_q(ctl_q), .fault_pending(fault_pending), .recover(recover)
  );

  bfm_status #(.STAT_W(STAT_W), .ERR_CODE(ERR_CODE)) u_status (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .code_q(code_q)
  );

  assign line_release = fault_pending;
  assign si_flag      = ctl_q.si;
  assign sta_flag     = ctl_q.sta;
  assign sto_flag     = ctl_q.sto;
  assign aa_flag      = ctl_q.aa;
  assign stop_req     = ctl_q.sto & (ctl_role == RL_MASTER) & ~fault_pending;
  assign status_code  = status_view(ctl_q.si, code_q, IDLE_CODE);
endmodule

// File: rtl/bfm_checker.sv
module bfm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_det,
  input logic       stop_det,
  input logic [1:0] frame_phase,
  input logic [1:0] ctl_role,
  input logic       bus_err_pulse,
  input logic       line_release,
  input logic       si_flag,
  input logic       sto_flag,
  input logic       stop_req,
  input logic [7:0] status_code
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_pulse |=> !bus_err_pulse); // R6

  AST_FAULT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_pulse |-> (si_flag && line_release && status_code == 8'h00)); // R5

  AST_IDLE_ROLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_det || stop_det) && (ctl_role == 2'd0 || ctl_role == 2'd3)) |=> !bus_err_pulse); // R3

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_det || stop_det) && frame_phase == 2'd0) |=> !bus_err_pulse); // R4

  AST_NO_STOP_IN_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    line_release |-> !stop_req); // R8

  AST_RECOVER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_release && sto_flag && !si_flag) |=> (!line_release && !sto_flag)); // R7

  AST_PENDING_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    line_release |=> !bus_err_pulse); // R10
endmodule

bind i2c_bus_fault_mon bfm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
  .frame_phase(frame_phase), .ctl_role(ctl_role), .bus_err_pulse(bus_err_pulse),
  .line_release(line_release), .si_flag(si_flag), .sto_flag(sto_flag),
  .stop_req(stop_req), .status_code(status_code)
);

// File: tb/i2c_bus_fault_mon_test.sv
module i2c_bus_fault_mon_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_det = 1'b0, stop_det = 1'b0;
  logic [1:0] frame_phase = 2'd0, ctl_role = 2'd0;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wdata = 4'd0;
  logic       stop_done = 1'b0;
  logic       bus_err_pulse, line_release, si_flag, sta_flag, sto_flag, aa_flag, stop_req;
  logic [7:0] status_code;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_bus_fault_mon uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    start_det = 1'b0; stop_det = 1'b0; ctl_we = 1'b0; stop_done = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 si", si_flag, 0);
    chk("R1 sto", sto_flag, 0);
    chk("R1 sta/aa", {sta_flag, aa_flag}, 0);
    chk("R1 release", line_release, 0);
    chk("R1 pulse", bus_err_pulse, 0);
    chk("R1 status", status_code, 8'hF8);

    // Sweep phase x role x condition kind
    for (int ph = 0; ph < 4; ph++)
      for (int rl = 0; rl < 4; rl++)
        for (int k = 0; k < 2; k++) begin
          automatic bit exp_err = (ph != 0) && (rl == 1 || rl == 2);
          frame_phase = ph[1:0]; ctl_role = rl[1:0];
          start_det = (k == 0); stop_det = (k == 1);
          step();
          idle_inputs();
          if (exp_err) begin
            chk("R2 pulse", bus_err_pulse, 1);
            chk("R5 si", si_flag, 1);
            chk("R5 status", status_code, 8'h00);
            chk("R5 release", line_release, 1);
          end else begin
            chk(ph == 0 ? "R4 no pulse" : "R3 no pulse", bus_err_pulse, 0);
            chk(ph == 0 ? "R4 status" : "R3 status", status_code, 8'hF8);
            chk(ph == 0 ? "R4 release" : "R3 release", line_release, 0);
          end
          step();
          chk("R2 pulse one cycle", bus_err_pulse, 0);
          if (exp_err) begin
            // R10: another misplaced condition while pending
            frame_phase = 2'd2; ctl_role = 2'd1; stop_det = 1'b1;
            step();
            idle_inputs();
            chk("R10 no pulse", bus_err_pulse, 0);
            chk("R10 status", status_code, 8'h00);
            ctl_role = rl[1:0];
            // R7 recovery write: sta=1 sto=1 si=0 aa=1
            ctl_we = 1'b1; ctl_wdata = 4'b1101;
            step();
            idle_inputs();
            chk("R7 sto held", sto_flag, 1);
            chk("R8 no stop in recovery", stop_req, 0);
            chk("R7 release held", line_release, 1);
            step();
            chk("R7 sto cleared", sto_flag, 0);
            chk("R7 release dropped", line_release, 0);
            chk("R7 status idle", status_code, 8'hF8);
            chk("R7 sta/aa kept", {sta_flag, aa_flag}, 2'b11);
            ctl_we = 1'b1; ctl_wdata = 4'b0000;
            step();
            idle_inputs();
          end
        end

    // R6: held condition gives one pulse
    begin
      automatic int pulses = 0;
      frame_phase = 2'd1; ctl_role = 2'd2; start_det = 1'b1;
      for (int c = 0; c < 4; c++) begin
        step();
        pulses += bus_err_pulse;
      end
      start_det = 1'b0;
      step();
      pulses += bus_err_pulse;
      chk("R6 one pulse", pulses, 1);
      ctl_we = 1'b1; ctl_wdata = 4'b0100;
      step(); idle_inputs();
      step();
      chk("R6 recovered", line_release, 0);
    end

    // R8 normal stop request and R9 flag and stop_done
    ctl_role = 2'd1; frame_phase = 2'd0;
    ctl_we = 1'b1; ctl_wdata = 4'b0110;
    step(); idle_inputs();
    chk("R9 si not settable", si_flag, 0);
    chk("R8 stop_req master", stop_req, 1);
    ctl_role = 2'd2;
    step();
    chk("R8 stop_req slave", stop_req, 0);
    stop_done = 1'b1;
    step(); idle_inputs();
    chk("R9 stop_done clears sto", sto_flag, 0);

    // R9 clearing the flag via write
    frame_phase = 2'd3; ctl_role = 2'd1; stop_det = 1'b1;
    step(); idle_inputs();
    chk("R9 flag set", si_flag, 1);
    ctl_we = 1'b1; ctl_wdata = 4'b0000;
    step(); idle_inputs();
    chk("R9 flag cleared", si_flag, 0);
    chk("R9 release still held", line_release, 1);
    ctl_we = 1'b1; ctl_wdata = 4'b0100;
    step(); idle_inputs();
    step();
    chk("R7 recovered", line_release, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule